// File: doc/BRIEF.md
# Strobed Parallel I/O Controller

This block gives a host two 8-bit parallel ports behind a small register bus. One port only drives outputs. The other is bidirectional, and a direction register controls it bit by bit. An external strobe input is synchronised, and its selected edge snapshots the bidirectional pins into a separate capture register. The same edge raises a status flag, which can drive an active-low interrupt.

The host clears the flag with a two-step read. It first reads the control register while the flag is set, then it reads the capture register. In the simple strobed mode, the strobe output gives a one-cycle pulse each time the host writes the output-only port. In input handshake mode, the same pin becomes a READY line to the external sender. READY drops when data is captured and comes back once the host has cleared the flag.

Top module: `pio_strobe_unit`

## Requirements
- R1: After reset, `outPort`, `bidirOut` and `bidirOe` are 0, `irqN` is 1, `strobeOut` is 0 and every readable register reads 0.
- R2: The register map is: address 0 control, 1 output-port data, 2 bidirectional port, 3 direction, 4 capture (read-only). In the control register, bit 0 selects handshake mode, bit 1 selects the strobe edge (1 rising, 0 falling) and bit 6 enables the interrupt. These bits read back as written. Bit 7 is the read-only strobe flag, and all other bits read 0.
- R3: With bit 1 = 1, a rising edge on `strobeIn` copies the pin values into the capture register and sets the flag. It does so on the third rising clock edge after the input changes.
- R4: With bit 1 = 0, a falling edge captures instead. The opposite edge leaves the capture register and the flag unchanged.
- R5: `irqN` is 0 exactly when both the flag and bit 6 are set.
- R6: The flag clears only when a capture-register read follows a control read made while the flag was set. A capture read alone does not clear it. A control read made while the flag is clear does not arm the clear either.
- R7: Every active edge reloads the capture register, even while the flag is still set.
- R8: A read at address 2 returns the stored latch value on bits whose direction bit is 1, and the `bidirIn` level on bits whose direction bit is 0.
- R9: `bidirOe` equals the direction register and `bidirOut` equals the bidirectional latch. A value written while a bit is an input appears on the pin once its direction bit is set.
- R10: In simple mode (bit 0 = 0), each write to address 1 updates `outPort` and makes `strobeOut` high for exactly the one cycle after the write.
- R11: In handshake mode, `strobeOut` is READY. It is low after a capture and high again once the clearing read sequence completes. Writes to address 1 produce no pulse in this mode.
- R12: If a capture and a clearing capture-register read fall in the same cycle, the capture wins. The flag stays set, READY stays low, and the capture register holds the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access select |
| busWr | input | 1 | Write enable |
| busRd | input | 1 | Read enable |
| busAddr | input | 3 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from the address |
| outPort | output | 8 | Output-only port |
| bidirIn | input | 8 | Bidirectional port pin levels |
| bidirOut | output | 8 | Bidirectional port drive value |
| bidirOe | output | 8 | Bidirectional port drive enables |
| strobeIn | input | 1 | External capture strobe |
| strobeOut | output | 1 | Write pulse or READY |
| irqN | output | 1 | Active-low interrupt |

## Verification
Two events can land in the same clock edge: a strobe capture, and the second read of the flag-clearing sequence. The bench arms the clear with a control read. It then toggles `strobeIn` and places the capture-register read exactly two cycles later, so that the read meets the synchroniser's capture edge. It judges the result at the ports: the flag and READY must show that the capture won, and the capture register must hold the new pattern. Around this case, sweeps cover direction/pin mixing, both strobe polarities and the pulse timing.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_OUT   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_BIDIR = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_DIR   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CAPT  = 3'd4;

  localparam int CTRL_HS   = 0;
  localparam int CTRL_EDGE = 1;
  localparam int CTRL_IE   = 6;
  localparam int CTRL_FLAG = 7;

  typedef struct packed {
    logic wrCtrl;
    logic wrOut;
    logic wrBidir;
    logic wrDir;
    logic capture;
  } dpStrobes_t;
endpackage

// File: rtl/pio_control.sv
module pio_control
  import pio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              strobeIn,
  input  logic              hsMode,
  input  logic              edgeRise,
  output dpStrobes_t        strobes,
  output logic              flag,
  output logic              strobeOut
);
  logic [SYNC_STAGES:0] syncChain;
  logic syncLevel, syncPrev, riseSeen, fallSeen;
  logic rdCtrl, rdCapt, clearReq;
  logic armed, ready, pulseReg;

  // synchroniser plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-1:0], strobeIn};
  end

  assign syncLevel = syncChain[SYNC_STAGES-1];
  assign syncPrev  = syncChain[SYNC_STAGES];
  assign riseSeen  = syncLevel & ~syncPrev;
  assign fallSeen  = ~syncLevel & syncPrev;

  always_comb begin
    strobes.wrCtrl  = busSel & busWr & (busAddr == ADDR_CTRL);
    strobes.wrOut   = busSel & busWr & (busAddr == ADDR_OUT);
    strobes.wrBidir = busSel & busWr & (busAddr == ADDR_BIDIR);
    strobes.wrDir   = busSel & busWr & (busAddr == ADDR_DIR);
    strobes.capture = edgeRise ? riseSeen : fallSeen;
  end

  assign rdCtrl   = busSel & busRd & (busAddr == ADDR_CTRL);
  assign rdCapt   = busSel & busRd & (busAddr == ADDR_CAPT);
  assign clearReq = rdCapt & armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      flag     <= 1'b0;
      ready    <= 1'b1;
      pulseReg <= 1'b0;
    end else begin
      if (rdCapt)             armed <= 1'b0;
      else if (rdCtrl && flag) armed <= 1'b1;

      if (strobes.capture)    flag <= 1'b1;
      else if (clearReq)      flag <= 1'b0;

      if (strobes.capture)    ready <= 1'b0;
      else if (clearReq)      ready <= 1'b1;

      pulseReg <= strobes.wrOut & ~hsMode;
    end
  end

  assign strobeOut = hsMode ? ready : pulseReg;

  a_r3_capture_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> flag);
  a_r6_flag_needs_arm: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !armed && !strobes.capture) |=> flag);
  a_r12_capture_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && clearReq) |=> (flag && !ready));
  a_r11_ready_drops: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> !ready);
  a_r10_pulse_from_write: assert property (@(posedge clk) disable iff (!rstN)
    pulseReg |-> $past(strobes.wrOut));
endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [W-1:0]      busWdata,
  input  logic [W-1:0]      bidirIn,
  input  logic              flag,
  output logic [W-1:0]      busRdata,
  output logic [W-1:0]      outPort,
  output logic [W-1:0]      bidirOut,
  output logic [W-1:0]      bidirOe,
  output logic              hsMode,
  output logic              edgeRise,
  output logic              intEn
);
  logic [W-1:0] outData, bidirLatch, dirReg, captReg, pinValue, ctrlView;

  assign pinValue = (dirReg & bidirLatch) | (~dirReg & bidirIn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData    <= '0;
      bidirLatch <= '0;
      dirReg     <= '0;
      captReg    <= '0;
      hsMode     <= 1'b0;
      edgeRise   <= 1'b0;
      intEn      <= 1'b0;
    end else begin
      if (strobes.wrOut)   outData    <= busWdata;
      if (strobes.wrBidir) bidirLatch <= busWdata;
      if (strobes.wrDir)   dirReg     <= busWdata;
      if (strobes.capture) captReg    <= pinValue;
      if (strobes.wrCtrl) begin
        hsMode   <= busWdata[CTRL_HS];
        edgeRise <= busWdata[CTRL_EDGE];
        intEn    <= busWdata[CTRL_IE];
      end
    end
  end

  always_comb begin
    ctrlView            = '0;
    ctrlView[CTRL_HS]   = hsMode;
    ctrlView[CTRL_EDGE] = edgeRise;
    ctrlView[CTRL_IE]   = intEn;
    ctrlView[CTRL_FLAG] = flag;
  end

  always_comb begin
    case (busAddr)
      ADDR_CTRL:  busRdata = ctrlView;
      ADDR_OUT:   busRdata = outData;
      ADDR_BIDIR: busRdata = pinValue;
      ADDR_DIR:   busRdata = dirReg;
      ADDR_CAPT:  busRdata = captReg;
      default:    busRdata = '0;
    endcase
  end

  assign outPort  = outData;
  assign bidirOut = bidirLatch;
  assign bidirOe  = dirReg;

  a_r7_capture_loads: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (captReg == $past(pinValue)));
  a_r10_out_update: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrOut |=> (outPort == $past(busWdata)));
endmodule

// File: rtl/pio_strobe_unit.sv
module pio_strobe_unit
  import pio_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [W-1:0]      busWdata,
  output logic [W-1:0]      busRdata,
  output logic [W-1:0]      outPort,
  input  logic [W-1:0]      bidirIn,
  output logic [W-1:0]      bidirOut,
  output logic [W-1:0]      bidirOe,
  input  logic              strobeIn,
  output logic              strobeOut,
  output logic              irqN
);
  dpStrobes_t strobes;
  logic flag, hsMode, edgeRise, intEn;

  pio_control #(.SYNC_STAGES(SYNC_STAGES)) i_control (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .strobeIn(strobeIn), .hsMode(hsMode), .edgeRise(edgeRise),
    .strobes(strobes), .flag(flag), .strobeOut(strobeOut)
  );

  pio_datapath #(.W(W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busAddr(busAddr),
    .busWdata(busWdata), .bidirIn(bidirIn), .flag(flag), .busRdata(busRdata),
    .outPort(outPort), .bidirOut(bidirOut), .bidirOe(bidirOe),
    .hsMode(hsMode), .edgeRise(edgeRise), .intEn(intEn)
  );

  assign irqN = ~(flag & intEn);
endmodule

// File: tb/test_pio_strobe_unit.sv
`timescale 1ns/1ps
module test_pio_strobe_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0, busRd = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0, busRdata, outPort, bidirIn = '0, bidirOut, bidirOe;
  logic strobeIn = 1'b0, strobeOut, irqN;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] rd;

  always #4 clk = ~clk;

  pio_strobe_unit i_pio_strobe_unit (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .outPort(outPort),
    .bidirIn(bidirIn), .bidirOut(bidirOut), .bidirOe(bidirOe),
    .strobeIn(strobeIn), .strobeOut(strobeOut), .irqN(irqN)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk); busSel = 0; busWr = 0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); busSel = 1; busRd = 1; busAddr = a;
    #1 d = busRdata;
    @(negedge clk); busSel = 0; busRd = 0;
  endtask

  task automatic strobeTo(input logic v);
    @(negedge clk); strobeIn = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 outPort", outPort, 8'h00);
    chk("R1 bidirOut", bidirOut, 8'h00);
    chk("R1 bidirOe", bidirOe, 8'h00);
    chk("R1 irqN", {7'd0, irqN}, 8'h01);
    chk("R1 strobeOut", {7'd0, strobeOut}, 8'h00);
    for (int a = 0; a < 5; a++) begin
      busRead(3'(a), rd); chk("R1 register", rd, 8'h00);
    end
    // R2 control register fields
    busWrite(3'd0, 8'hFF); busRead(3'd0, rd); chk("R2 ctrl readback", rd, 8'h43);
    busWrite(3'd0, 8'h42); busRead(3'd0, rd); chk("R2 ctrl readback", rd, 8'h42);
    // R8 and R9 sweep over direction masks and patterns
    for (int d = 0; d < 4; d++) begin
      for (int v = 0; v < 16; v++) begin
        logic [7:0] dirv, val, pin;
        dirv = 8'(d * 85);
        val  = 8'(v * 29 + 3);
        pin  = ~val ^ 8'(v * 4);
        busWrite(3'd2, val);
        busWrite(3'd3, dirv);
        bidirIn = pin;
        busRead(3'd2, rd);
        chk("R8 port read mix", rd, (dirv & val) | (~dirv & pin));
        chk("R9 oe", bidirOe, dirv);
        chk("R9 drive", bidirOut, val);
      end
    end
    // R9 preset before turning on the driver
    busWrite(3'd3, 8'h00); busWrite(3'd2, 8'h5A);
    chk("R9 preset hidden", bidirOe, 8'h00);
    busWrite(3'd3, 8'hFF);
    chk("R9 preset drives", bidirOut, 8'h5A);
    chk("R9 preset oe", bidirOe, 8'hFF);
    busWrite(3'd3, 8'h00);
    // R3, R5, R6 rising-edge capture and two-step clear
    bidirIn = 8'h96; strobeTo(1);
    chk("R5 irq asserted", {7'd0, irqN}, 8'h00);
    busRead(3'd4, rd); chk("R3 captured", rd, 8'h96);
    busRead(3'd0, rd); chk("R6 capture read alone keeps flag", rd, 8'hC2);
    busRead(3'd4, rd);
    busRead(3'd0, rd); chk("R6 flag cleared", rd, 8'h42);
    chk("R5 irq released", {7'd0, irqN}, 8'h01);
    // R4 opposite edge ignored
    bidirIn = 8'h77; strobeTo(0);
    busRead(3'd4, rd); chk("R4 falling ignored in rising mode", rd, 8'h96);
    chk("R4 no flag", {7'd0, irqN}, 8'h01);
    // R6 control read with clear flag does not arm
    busRead(3'd0, rd);
    bidirIn = 8'h5C; strobeTo(1);
    busRead(3'd4, rd); chk("R6 capture", rd, 8'h5C);
    busRead(3'd0, rd); chk("R6 unarmed read kept flag", rd, 8'hC2);
    busRead(3'd4, rd);
    busRead(3'd0, rd); chk("R6 cleared", rd, 8'h42);
    // R7 reload while flag set
    strobeTo(0); bidirIn = 8'h11; strobeTo(1);
    strobeTo(0); bidirIn = 8'h22; strobeTo(1);
    busRead(3'd4, rd); chk("R7 newest data", rd, 8'h22);
    busRead(3'd0, rd); chk("R7 flag still set", rd, 8'hC2);
    busRead(3'd4, rd);
    // R4 falling-edge sweep with mixed directions
    busWrite(3'd0, 8'h40);
    for (int k = 0; k < 8; k++) begin
      logic [7:0] dirv, lat, pin, exp;
      dirv = 8'(k * 36); lat = 8'hA5 ^ 8'(k); pin = 8'(k * 53 + 7);
      exp = (dirv & lat) | (~dirv & pin);
      busWrite(3'd3, dirv); busWrite(3'd2, lat);
      bidirIn = pin; strobeTo(0);
      chk("R5 irq on falling capture", {7'd0, irqN}, 8'h00);
      bidirIn = ~pin; strobeTo(1);
      busRead(3'd0, rd); chk("R4 flag via ctrl", rd, 8'hC0);
      busRead(3'd4, rd); chk("R4 falling capture", rd, exp);
      chk("R6 irq cleared", {7'd0, irqN}, 8'h01);
    end
    busWrite(3'd3, 8'h00);
    // R10 write pulse in simple mode
    busWrite(3'd0, 8'h00);
    for (int k = 0; k < 8; k++) begin
      logic [7:0] val;
      val = 8'(k * 37 + 1);
      busWrite(3'd1, val);
      chk("R10 pulse high", {7'd0, strobeOut}, 8'h01);
      chk("R10 outPort", outPort, val);
      @(negedge clk);
      chk("R10 pulse one cycle", {7'd0, strobeOut}, 8'h00);
      busRead(3'd1, rd); chk("R10 readback", rd, val);
    end
    // R11 handshake READY (strobe level is 1, flag clear)
    busWrite(3'd0, 8'h03);
    chk("R11 ready high", {7'd0, strobeOut}, 8'h01);
    busWrite(3'd1, 8'h81);
    chk("R11 no pulse", {7'd0, strobeOut}, 8'h01);
    strobeTo(0); bidirIn = 8'hC3; strobeTo(1);
    chk("R11 ready drops", {7'd0, strobeOut}, 8'h00);
    busRead(3'd0, rd); chk("R11 flag", rd, 8'h83);
    chk("R11 ready low mid-sequence", {7'd0, strobeOut}, 8'h00);
    busRead(3'd4, rd); chk("R11 data", rd, 8'hC3);
    chk("R11 ready back", {7'd0, strobeOut}, 8'h01);
    // R12 capture meets clearing read in the same cycle
    strobeTo(0); bidirIn = 8'h3E; strobeTo(1);
    busRead(3'd0, rd);
    strobeTo(0); bidirIn = 8'hE7;
    @(negedge clk); strobeIn = 1'b1;
    @(negedge clk);
    @(negedge clk); busSel = 1; busRd = 1; busAddr = 3'd4;
    @(negedge clk); busSel = 0; busRd = 0;
    busRead(3'd4, rd); chk("R12 new data kept", rd, 8'hE7);
    busRead(3'd0, rd); chk("R12 flag survives", rd, 8'h83);
    chk("R12 ready stays low", {7'd0, strobeOut}, 8'h00);
    busRead(3'd4, rd);
    chk("R12 later clear works", {7'd0, strobeOut}, 8'h01);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule